// File: doc/BRIEF.md
# Interrupt Cause Aggregation Controller

This block collects interrupt causes from two places and reduces them to a single interrupt request for one CPU. The first place is a 32-bit general-purpose-pin cause word. Logic outside the block loads, sets or clears it, and software qualifies it with a pin mask. The second place is a serial-DMA cause register. Outside sources raise its bits, and software clears them.

The block folds both sources into a high main cause word. Each byte of the masked pin word produces one summary bit. Any nonzero DMA cause produces one more summary bit. A low main cause word is also provided, and it currently has no sources. Each main cause word is gated by its own CPU mask. The result drives a registered interrupt line.

Software reaches every register through a simple 32-bit register port. It raises a write strobe or a read strobe against a 16-bit byte offset. Both strobes are plain single-cycle controls with no back-pressure: the block accepts any access in the cycle it is presented. Read data returns one cycle later.

Top module: `irq_sum_ctrl`

## Requirements
- R1: Out of reset every register is zero, `irq_o` is low and every read returns zero.
- R2: The low main cause word at offset 0x0004 always reads zero. Writes to 0x0004 and to the high main cause word at 0x000C change no register.
- R3: Bit 4 of the high main cause word (offset 0x000C) is 1 exactly when any bit of the DMA cause register is 1.
- R4: Bits 24, 25, 26 and 27 of the high main cause word are 1 exactly when (pin cause AND pin mask) is nonzero in byte 0, 1, 2 and 3 respectively. Every other bit of the word, apart from bit 4, reads zero.
- R5: `irq_o` is a register. One cycle after any register changes, it equals the OR-reduction of (low cause AND CPU mask low) OR (high cause AND CPU mask high).
- R6: A write to the DMA cause register (offset 0xB800) replaces it with its old value ANDed with the write data. Bits pulsed on `dma_raise` in the same cycle are ORed in afterwards, so a raise wins over a clear.
- R7: The pin cause word is updated in three steps, in this order. First, `pin_load` replaces the whole word with `pin_load_val`. Next, `pin_set` sets bit `pin_set_idx`. Last, `pin_clr` clears bit `pin_clr_idx`, so a clear wins over a set or a load on the same bit.
- R8: The CPU mask low (0x0014), the CPU mask high (0x001C) and the pin mask (0xF10C) are read/write. The pin cause word (0xF108) is read-only from the port.
- R9: A read of any other offset returns zero. A write to any other offset changes no register.
- R10: `rdata` is registered. It shows the addressed value in the cycle after `rd_en`, and it is zero in the cycle after any cycle without `rd_en`. When a read and a write hit the same offset in one cycle, the read returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 16 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| pin_load | input | 1 | Load the whole pin cause word |
| pin_load_val | input | 32 | Value for `pin_load` |
| pin_set | input | 1 | Set one pin cause bit |
| pin_set_idx | input | 5 | Bit index for `pin_set` |
| pin_clr | input | 1 | Clear one pin cause bit |
| pin_clr_idx | input | 5 | Bit index for `pin_clr` |
| dma_raise | input | 8 | DMA cause bits to raise |
| irq_o | output | 1 | CPU interrupt request |

## Verification
The bench sets a pin bit and clears the same bit in one cycle. A design that got the order wrong would leave that bit set. It also raises and clears the same DMA bit in one cycle; a design with the wrong order would lose the raise. It writes to the read-only and unmapped offsets, then reads every mask back. A design that decoded loosely would alter a mask or return nonzero data. Random stimulus puts single cause bits on byte edges, so a design with a misplaced byte group would set the wrong summary bit. It also checks the one-cycle lag of `irq_o`; a design that drove the line combinationally would change it early.

// File: rtl/irq_sum_pkg.sv
package irq_sum_pkg;
  localparam int ADDR_W = 16;

  localparam logic [ADDR_W-1:0] OFS_LO_CAUSE  = 16'h0004;
  localparam logic [ADDR_W-1:0] OFS_HI_CAUSE  = 16'h000C;
  localparam logic [ADDR_W-1:0] OFS_MASK_LO   = 16'h0014;
  localparam logic [ADDR_W-1:0] OFS_MASK_HI   = 16'h001C;
  localparam logic [ADDR_W-1:0] OFS_PIN_CAUSE = 16'hF108;
  localparam logic [ADDR_W-1:0] OFS_PIN_MASK  = 16'hF10C;
  localparam logic [ADDR_W-1:0] OFS_DMA_CAUSE = 16'hB800;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LO_CAUSE,
    SEL_HI_CAUSE,
    SEL_MASK_LO,
    SEL_MASK_HI,
    SEL_PIN_CAUSE,
    SEL_PIN_MASK,
    SEL_DMA_CAUSE
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_LO_CAUSE:  return SEL_LO_CAUSE;
      OFS_HI_CAUSE:  return SEL_HI_CAUSE;
      OFS_MASK_LO:   return SEL_MASK_LO;
      OFS_MASK_HI:   return SEL_MASK_HI;
      OFS_PIN_CAUSE: return SEL_PIN_CAUSE;
      OFS_PIN_MASK:  return SEL_PIN_MASK;
      OFS_DMA_CAUSE: return SEL_DMA_CAUSE;
      default:       return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irq_sum_pin.sv
module irq_sum_pin #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              set,
  input  logic [IDX_W-1:0]  set_idx,
  input  logic              clr,
  input  logic [IDX_W-1:0]  clr_idx,
  output logic [DATA_W-1:0] pin_cause
);
  logic [DATA_W-1:0] nxt;

  always_comb begin
    nxt = load ? load_val : pin_cause;
    if (set) nxt[set_idx] = 1'b1;
    if (clr) nxt[clr_idx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pin_cause <= '0;
    else        pin_cause <= nxt;
  end

  AST_PIN_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pin_cause[$past(clr_idx)]); // R7
  AST_PIN_SET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (set && !(clr && clr_idx == set_idx)) |=> pin_cause[$past(set_idx)]); // R7
  AST_PIN_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !set && !clr) |=> $stable(pin_cause)); // R7
endmodule

// File: rtl/irq_sum_regs.sv
module irq_sum_regs
  import irq_sum_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DMA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          wsel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DMA_W-1:0]  dma_raise,
  output logic [DATA_W-1:0] mask_lo,
  output logic [DATA_W-1:0] mask_hi,
  output logic [DATA_W-1:0] pin_mask,
  output logic [DMA_W-1:0]  dma_cause
);
  logic             wr_dma;
  logic [DMA_W-1:0] dma_kept;

  assign wr_dma   = wr_en && (wsel == SEL_DMA_CAUSE);
  assign dma_kept = wr_dma ? (dma_cause & wdata[DMA_W-1:0]) : dma_cause;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_lo   <= '0;
      mask_hi   <= '0;
      pin_mask  <= '0;
      dma_cause <= '0;
    end else begin
      if (wr_en && wsel == SEL_MASK_LO) mask_lo  <= wdata;
      if (wr_en && wsel == SEL_MASK_HI) mask_hi  <= wdata;
      if (wr_en && wsel == SEL_PIN_MASK) pin_mask <= wdata;
      dma_cause <= dma_kept | dma_raise;
    end
  end

  AST_DMA_NO_NEW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_raise == '0) |=> ((dma_cause & ~$past(dma_cause)) == '0)); // R6
  AST_DMA_RAISE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_raise != '0) |=> ((dma_cause & $past(dma_raise)) == $past(dma_raise))); // R6
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(mask_lo) && $stable(mask_hi) && $stable(pin_mask))); // R8
  AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wsel == SEL_HI_CAUSE || wsel == SEL_LO_CAUSE || wsel == SEL_NONE))
      |=> ($stable(mask_lo) && $stable(mask_hi) && $stable(pin_mask))); // R2
endmodule

// File: rtl/irq_sum_fold.sv
module irq_sum_fold #(
  parameter int DATA_W      = 32,
  parameter int DMA_W       = 8,
  parameter int GROUP_W     = 8,
  parameter int GROUP_BASE  = 24,
  parameter int DMA_SUM_BIT = 4,
  localparam int N_GROUPS   = DATA_W / GROUP_W
) (
  input  logic [DATA_W-1:0] pin_cause,
  input  logic [DATA_W-1:0] pin_mask,
  input  logic [DMA_W-1:0]  dma_cause,
  output logic [DATA_W-1:0] lo_cause,
  output logic [DATA_W-1:0] hi_cause
);
  logic [DATA_W-1:0]   pin_live;
  logic [N_GROUPS-1:0] grp_hit;

  assign pin_live = pin_cause & pin_mask;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    assign grp_hit[g] = |pin_live[g*GROUP_W +: GROUP_W];
  end

  always_comb begin
    hi_cause = '0;
    hi_cause[DMA_SUM_BIT] = |dma_cause;
    hi_cause[GROUP_BASE +: N_GROUPS] = grp_hit;
    lo_cause = '0;
  end
endmodule

// File: rtl/irq_sum_ctrl.sv
module irq_sum_ctrl
  import irq_sum_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DMA_W  = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              pin_load,
  input  logic [DATA_W-1:0] pin_load_val,
  input  logic              pin_set,
  input  logic [IDX_W-1:0]  pin_set_idx,
  input  logic              pin_clr,
  input  logic [IDX_W-1:0]  pin_clr_idx,
  input  logic [DMA_W-1:0]  dma_raise,
  output logic              irq_o
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] mask_lo, mask_hi, pin_mask, pin_cause;
  logic [DMA_W-1:0]  dma_cause;
  logic [DATA_W-1:0] lo_cause, hi_cause;
  logic [DATA_W-1:0] rd_mux;
  logic              irq_nxt;

  assign sel = decode_ofs(addr);

  irq_sum_pin #(.DATA_W(DATA_W)) u_pin (
    .clk(clk), .rst_n(rst_n),
    .load(pin_load), .load_val(pin_load_val),
    .set(pin_set), .set_idx(pin_set_idx),
    .clr(pin_clr), .clr_idx(pin_clr_idx),
    .pin_cause(pin_cause)
  );

  irq_sum_regs #(.DATA_W(DATA_W), .DMA_W(DMA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wsel(sel), .wdata(wdata),
    .dma_raise(dma_raise),
    .mask_lo(mask_lo), .mask_hi(mask_hi),
    .pin_mask(pin_mask), .dma_cause(dma_cause)
  );

  irq_sum_fold #(.DATA_W(DATA_W), .DMA_W(DMA_W)) u_fold (
    .pin_cause(pin_cause), .pin_mask(pin_mask), .dma_cause(dma_cause),
    .lo_cause(lo_cause), .hi_cause(hi_cause)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_LO_CAUSE:  rd_mux = lo_cause;
      SEL_HI_CAUSE:  rd_mux = hi_cause;
      SEL_MASK_LO:   rd_mux = mask_lo;
      SEL_MASK_HI:   rd_mux = mask_hi;
      SEL_PIN_CAUSE: rd_mux = pin_cause;
      SEL_PIN_MASK:  rd_mux = pin_mask;
      SEL_DMA_CAUSE: rd_mux[DMA_W-1:0] = dma_cause;
      default:       rd_mux = '0;
    endcase
  end

  assign irq_nxt = (|(lo_cause & mask_lo)) || (|(hi_cause & mask_hi));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      irq_o <= 1'b0;
    end else begin
      rdata <= rd_en ? rd_mux : '0;
      irq_o <= irq_nxt;
    end
  end

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_lo == '0 && mask_hi == '0) |=> !irq_o); // R5
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == '0)); // R10
  AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_NONE) |=> (rdata == '0)); // R9
  AST_LO_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_LO_CAUSE) |=> (rdata == '0)); // R2
  AST_DMA_SUM_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_HI_CAUSE) |=> (rdata[4] == (|$past(dma_cause)))); // R3
endmodule

// File: tb/irq_sum_ctrl_tb.sv
module irq_sum_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pin_load = 1'b0;
  logic [31:0] pin_load_val = '0;
  logic        pin_set = 1'b0, pin_clr = 1'b0;
  logic [4:0]  pin_set_idx = '0, pin_clr_idx = '0;
  logic [7:0]  dma_raise = '0;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] m_mlo = '0, m_mhi = '0, m_pmask = '0, m_pin = '0;
  logic [7:0]  m_dma = '0;

  always #2 clk = ~clk;

  irq_sum_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .pin_load(pin_load), .pin_load_val(pin_load_val),
    .pin_set(pin_set), .pin_set_idx(pin_set_idx),
    .pin_clr(pin_clr), .pin_clr_idx(pin_clr_idx),
    .dma_raise(dma_raise), .irq_o(irq_o)
  );

  function automatic logic [31:0] exp_hi();
    logic [31:0] h = '0;
    logic [31:0] live = m_pin & m_pmask;
    h[4] = |m_dma;
    for (int g = 0; g < 4; g++) h[24+g] = |live[g*8 +: 8];
    return h;
  endfunction

  function automatic logic exp_irq();
    return |(exp_hi() & m_mhi);
  endfunction

  function automatic logic [31:0] exp_read(input logic [15:0] a);
    case (a)
      16'h000C: return exp_hi();
      16'h0014: return m_mlo;
      16'h001C: return m_mhi;
      16'hF108: return m_pin;
      16'hF10C: return m_pmask;
      16'hB800: return {24'h0, m_dma};
      default:  return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
    case (a)
      16'h0014: m_mlo = d;
      16'h001C: m_mhi = d;
      16'hF10C: m_pmask = d;
      16'hB800: m_dma = m_dma & d[7:0];
      default: ;
    endcase
  endtask

  task automatic bus_read(input string req, input logic [15:0] a);
    logic [31:0] e;
    e = exp_read(a);
    addr = a; rd_en = 1'b1;
    step();
    rd_en = 1'b0;
    check(req, rdata, e);
  endtask

  task automatic pin_op(input bit ld, input logic [31:0] v, input bit st,
                        input logic [4:0] si, input bit cl, input logic [4:0] ci);
    pin_load = ld; pin_load_val = v; pin_set = st; pin_set_idx = si;
    pin_clr = cl; pin_clr_idx = ci;
    step();
    pin_load = 1'b0; pin_set = 1'b0; pin_clr = 1'b0;
    if (ld) m_pin = v;
    if (st) m_pin[si] = 1'b1;
    if (cl) m_pin[ci] = 1'b0;
  endtask

  task automatic irq_check(input string req);
    step();
    check(req, {31'h0, irq_o}, {31'h0, exp_irq()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] addrs [8];
    int unsigned seed;
    addrs = '{16'h0004, 16'h000C, 16'h0014, 16'h001C, 16'hF108, 16'hF10C, 16'hB800, 16'h1234};
    seed = 32'd12345;
    void'($urandom(seed));
    repeat (3) step();
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'h0, irq_o}, 32'h0);
    for (int i = 0; i < 7; i++) bus_read("R1 reset read", addrs[i]);

    // R8 masks read/write, R2 read-only writes ignored
    bus_write(16'h0014, 32'hA5A5_0F0F);
    bus_write(16'h001C, 32'h0F00_0010);
    bus_write(16'hF10C, 32'hFFFF_FFFF);
    bus_write(16'h000C, 32'hFFFF_FFFF);
    bus_write(16'h0004, 32'hFFFF_FFFF);
    bus_write(16'hF108, 32'hFFFF_FFFF);
    bus_read("R8 mask lo", 16'h0014);
    bus_read("R8 mask hi", 16'h001C);
    bus_read("R8 pin mask", 16'hF10C);
    bus_read("R8 pin cause read-only", 16'hF108);
    bus_read("R2 lo cause zero", 16'h0004);

    // R9 unmapped write ignored, read zero
    bus_write(16'h2004, 32'hDEAD_BEEF);
    bus_read("R9 unmapped read", 16'h2004);
    bus_read("R9 masks untouched", 16'h001C);

    // R5 timing: set pin bit 9 -> byte 1 -> hi bit 25, masked in
    pin_load = 1'b1; pin_load_val = 32'h0000_0200;
    step();
    pin_load = 1'b0; m_pin = 32'h0000_0200;
    check("R5 irq lags one cycle", {31'h0, irq_o}, 32'h0);
    step();
    check("R5 irq after one cycle", {31'h0, irq_o}, 32'h1);
    bus_read("R4 byte1 summary", 16'h000C);

    // R7 set and clear same bit: clear wins
    pin_op(1'b0, '0, 1'b1, 5'd31, 1'b1, 5'd31);
    bus_read("R7 clear wins over set", 16'hF108);
    pin_op(1'b1, 32'h8000_0001, 1'b1, 5'd4, 1'b1, 5'd0);
    bus_read("R7 load then set then clear", 16'hF108);
    bus_read("R4 byte0 and byte3", 16'h000C);

    // R6 raise wins over clear in the same cycle
    dma_raise = 8'h05;
    step();
    dma_raise = 8'h00; m_dma = 8'h05;
    bus_read("R6 raise", 16'hB800);
    bus_read("R3 dma summary set", 16'h000C);
    addr = 16'hB800; wdata = 32'h0; wr_en = 1'b1; dma_raise = 8'h04;
    step();
    wr_en = 1'b0; dma_raise = 8'h00; m_dma = 8'h04;
    bus_read("R6 raise beats clear", 16'hB800);
    bus_write(16'hB800, 32'hFFFF_FFFB);
    bus_read("R6 and-clear", 16'hB800);
    bus_read("R3 dma summary clear", 16'h000C);

    // R10 read and write same cycle returns old value
    addr = 16'h0014; wdata = 32'h1111_2222; wr_en = 1'b1; rd_en = 1'b1;
    step();
    wr_en = 1'b0; rd_en = 1'b0;
    check("R10 read returns old value", rdata, m_mlo);
    m_mlo = 32'h1111_2222;
    step();
    check("R10 idle rdata zero", rdata, 32'h0);

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int unsigned op = $urandom_range(0, 4);
      logic [15:0] a = ($urandom_range(0, 9) == 0) ? 16'($urandom) : addrs[$urandom_range(0, 7)];
      case (op)
        0: bus_write(a, (a == 16'hB800) ? $urandom : (32'h1 << $urandom_range(0, 31)) | $urandom);
        1: bus_read("R4 R8 random read", a);
        2: pin_op($urandom_range(0, 3) == 0, 32'h1 << $urandom_range(0, 31),
                  $urandom_range(0, 1) == 1, 5'($urandom), $urandom_range(0, 1) == 1, 5'($urandom));
        3: begin
          logic [7:0] r = 8'($urandom);
          dma_raise = r;
          step();
          dma_raise = '0; m_dma = m_dma | r;
        end
        default: bus_write(16'h001C, $urandom);
      endcase
      irq_check("R5 random irq");
    end

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule